// File: doc/BRIEF.md
# Two-by-two butterfly routing switch

This block is one switching element of a binary butterfly (2-ary n-fly) network. It has two input links and two output links. Every link carries a word made of a destination index and a payload, and it uses a ready/acknowledge handshake. The element is built for a fixed stage of the network and a fixed level within that stage. It routes each word deterministically by comparing a single bit of the word's destination with the same bit of its own level. The bit is chosen by the stage index.

Output port 0 is the straight link, which leads to the same level of the next stage. Output port 1 is the oblique link, which leads to the level that differs in the bit of the current stage. Each output holds one word. When the two inputs ask for different free outputs, both are served in the same cycle. When they ask for the same output, a round-robin choice picks one, and the other input waits without an acknowledge. A network is built by placing many copies side by side and wiring each output to an input of the next stage.

Top module: `bfly_switch2x2`

## Requirements
- R1: While reset is applied, and in the cycles after it before any word is offered, `out_rdy` and `in_ack` are both 0.
- R2: A word whose destination bit at position `STAGE` equals bit `STAGE` of `LEVEL` leaves on output 0 (straight). All other destination bits play no part in the choice.
- R3: A word whose destination bit at position `STAGE` differs from bit `STAGE` of `LEVEL` leaves on output 1 (oblique). The destination and payload are forwarded unchanged.
- R4: A word is taken at a clock edge where its input has `in_rdy` high, that input's `in_ack` is low, the target output is empty and the input holds the grant. In the cycle after that edge, `in_ack` of that input is high for exactly one cycle and the word appears on its output with `out_rdy` high.
- R5: When both inputs offer words for different outputs that are both empty, both words are taken at the same edge.
- R6: When both inputs offer words for the same empty output, exactly one is taken. The losing input gets no `in_ack`. After reset input 0 is preferred on each output. After every grant on an output, preference on that output passes to the input that was not granted.
- R7: An output keeps `out_rdy`, `out_dest` and `out_data` unchanged until `out_ack` is high at a clock edge. That edge empties it, so `out_rdy` is 0 in the following cycle.
- R8: While an output is full, no word is taken for it, including in the cycle in which it is emptied. A waiting input is taken at the first edge after the output has become empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_rdy | input | 2 | Per input: a word is offered |
| in_dest | input | 2 x DEST_W | Per input: destination index of the offered word |
| in_data | input | 2 x DATA_W | Per input: payload of the offered word |
| in_ack | output | 2 | Per input: one-cycle pulse, the word was taken |
| out_rdy | output | 2 | Per output (0 straight, 1 oblique): a word is held |
| out_dest | output | 2 x DEST_W | Per output: destination of the held word |
| out_data | output | 2 x DATA_W | Per output: payload of the held word |
| out_ack | input | 2 | Per output: downstream took the held word |

## Verification
The assertions assume that a sender keeps `in_rdy` and its word steady until it sees `in_ack`. They also assume that downstream raises `out_ack` only while `out_rdy` is high. The bench's senders follow this rule: they change a word only in the cycle in which its acknowledge is visible. The bench's sinks drive `out_ack` only from the `out_rdy` they observe in the same cycle. Directed cases cover the straight and oblique routes, parallel service, contention on both outputs and a full output that blocks a waiting input. A stream phase then sends mixed destinations into sinks that stall now and then.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  typedef enum logic {
    PORT_STRAIGHT = 1'b0,
    PORT_OBLIQUE  = 1'b1
  } bfly_port_e;
endpackage

// File: rtl/bfly_route.sv
module bfly_route
  import bfly_pkg::*;
#(
  parameter int DEST_W = 3,
  parameter int STAGE  = 1,
  parameter int LEVEL  = 5
) (
  input  logic [DEST_W-1:0] dest,
  output bfly_port_e        port_sel
);
  localparam logic OWN_BIT = ((LEVEL >> STAGE) & 1) != 0;

  always_comb begin
    if (dest[STAGE] == OWN_BIT) port_sel = PORT_STRAIGHT;
    else                        port_sel = PORT_OBLIQUE;
  end
endmodule

// File: rtl/bfly_rr_arb.sv
module bfly_rr_arb (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req,
  input  logic       avail,
  output logic [1:0] gnt
);
  logic prio_q;
  logic prio_d;
  logic prio_en;

  always_comb begin
    gnt = 2'b00;
    if (avail) begin
      case (req)
        2'b01:   gnt = 2'b01;
        2'b10:   gnt = 2'b10;
        2'b11:   gnt = prio_q ? 2'b10 : 2'b01;
        default: gnt = 2'b00;
      endcase
    end
  end

  always_comb begin
    prio_en = |gnt;
    prio_d  = gnt[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prio_q <= 1'b0;
    else if (prio_en) prio_q <= prio_d;
  end

  // R6: never both inputs granted on one output
  a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  // R6: contention on an empty output always yields a winner
  a_r6_contention_served: assert property (@(posedge clk) disable iff (!rst_n)
    (avail && req == 2'b11) |-> $countones(gnt) == 1);
endmodule

// File: rtl/bfly_out_slot.sv
module bfly_out_slot #(
  parameter int DEST_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DEST_W-1:0] load_dest,
  input  logic [DATA_W-1:0] load_data,
  input  logic              ack,
  output logic              rdy,
  output logic [DEST_W-1:0] dest,
  output logic [DATA_W-1:0] data
);
  logic full_q;
  logic full_d;
  logic [DEST_W-1:0] dest_q;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    full_d = full_q;
    if (load)     full_d = 1'b1;
    else if (ack) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      dest_q <= load_dest;
      data_q <= load_data;
    end
  end

  assign rdy  = full_q;
  assign dest = dest_q;
  assign data = data_q;

  // R7: a held word stays put until it is acknowledged
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && !ack) |=> (rdy && $stable(dest) && $stable(data)));
  // R7/R8: the acknowledge edge empties the slot, nothing refills it there
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && ack) |=> !rdy);
endmodule

// File: rtl/bfly_switch2x2.sv
module bfly_switch2x2
  import bfly_pkg::*;
#(
  parameter int DEST_W = 3,
  parameter int DATA_W = 8,
  parameter int STAGE  = 1,
  parameter int LEVEL  = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             in_rdy,
  input  logic [1:0][DEST_W-1:0] in_dest,
  input  logic [1:0][DATA_W-1:0] in_data,
  output logic [1:0]             in_ack,
  output logic [1:0]             out_rdy,
  output logic [1:0][DEST_W-1:0] out_dest,
  output logic [1:0][DATA_W-1:0] out_data,
  input  logic [1:0]             out_ack
);
  localparam int  NPORT   = 2;
  localparam logic OWN_BIT = ((LEVEL >> STAGE) & 1) != 0;

  // reset: asynchronous assertion, synchronous release
  logic rst_meta_q;
  logic rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  bfly_port_e           sel     [NPORT];
  logic [NPORT-1:0]     elig;
  logic [NPORT-1:0]     ack_q;
  logic [NPORT-1:0]     ack_d;
  logic [NPORT-1:0]     req_o   [NPORT];
  logic [NPORT-1:0]     gnt_o   [NPORT];
  logic [NPORT-1:0]     load_o;
  logic [DEST_W-1:0]    ldest_o [NPORT];
  logic [DATA_W-1:0]    ldata_o [NPORT];

  genvar gi;
  generate
    for (gi = 0; gi < NPORT; gi++) begin : g_in
      bfly_route #(.DEST_W(DEST_W), .STAGE(STAGE), .LEVEL(LEVEL)) u_route (
        .dest     (in_dest[gi]),
        .port_sel (sel[gi])
      );
      assign elig[gi] = in_rdy[gi] && !ack_q[gi];
    end
  endgenerate

  genvar go;
  generate
    for (go = 0; go < NPORT; go++) begin : g_out
      always_comb begin
        for (int i = 0; i < NPORT; i++)
          req_o[go][i] = elig[i] && (sel[i] == bfly_port_e'(go));
      end

      bfly_rr_arb u_arb (
        .clk   (clk),
        .rst_n (rst_sync_q),
        .req   (req_o[go]),
        .avail (!out_rdy[go]),
        .gnt   (gnt_o[go])
      );

      always_comb begin
        load_o[go]  = |gnt_o[go];
        ldest_o[go] = gnt_o[go][1] ? in_dest[1] : in_dest[0];
        ldata_o[go] = gnt_o[go][1] ? in_data[1] : in_data[0];
      end

      bfly_out_slot #(.DEST_W(DEST_W), .DATA_W(DATA_W)) u_slot (
        .clk       (clk),
        .rst_n     (rst_sync_q),
        .load      (load_o[go]),
        .load_dest (ldest_o[go]),
        .load_data (ldata_o[go]),
        .ack       (out_ack[go]),
        .rdy       (out_rdy[go]),
        .dest      (out_dest[go]),
        .data      (out_data[go])
      );
    end
  endgenerate

  // acknowledge pulse per input: set by a grant from either output
  always_comb begin
    for (int i = 0; i < NPORT; i++)
      ack_d[i] = gnt_o[0][i] || gnt_o[1][i];
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) ack_q <= '0;
    else             ack_q <= ack_d;
  end

  assign in_ack = ack_q;

  // R2: the straight output only ever holds words whose bit matches the level
  a_r2_straight_route: assert property (@(posedge clk) disable iff (!rst_sync_q)
    out_rdy[0] |-> (out_dest[0][STAGE] == OWN_BIT));
  // R3: the oblique output only ever holds words whose bit differs
  a_r3_oblique_route: assert property (@(posedge clk) disable iff (!rst_sync_q)
    out_rdy[1] |-> (out_dest[1][STAGE] != OWN_BIT));
  // R4: each acknowledge lasts one cycle
  a_r4_ack_pulse0: assert property (@(posedge clk) disable iff (!rst_sync_q)
    in_ack[0] |=> !in_ack[0]);
  a_r4_ack_pulse1: assert property (@(posedge clk) disable iff (!rst_sync_q)
    in_ack[1] |=> !in_ack[1]);
  // R4: an acknowledge always comes with a word now held on some output
  a_r4_ack_with_word: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (|in_ack) |-> (|out_rdy));
endmodule

// File: tb/sim_bfly_switch2x2.sv
`timescale 1ns/1ps
module sim_bfly_switch2x2;
  localparam int DEST_W = 3;
  localparam int DATA_W = 8;
  localparam int STAGE  = 1;
  localparam int LEVEL  = 5;
  localparam int NW     = 40;
  localparam int WDOG   = 20000;

  logic                   clk = 1'b0;
  logic                   rst_n;
  logic [1:0]             in_rdy;
  logic [1:0][DEST_W-1:0] in_dest;
  logic [1:0][DATA_W-1:0] in_data;
  logic [1:0]             in_ack;
  logic [1:0]             out_rdy;
  logic [1:0][DEST_W-1:0] out_dest;
  logic [1:0][DATA_W-1:0] out_data;
  logic [1:0]             out_ack;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  bfly_switch2x2 #(.DEST_W(DEST_W), .DATA_W(DATA_W), .STAGE(STAGE), .LEVEL(LEVEL)) u0 (
    .clk(clk), .rst_n(rst_n), .in_rdy(in_rdy), .in_dest(in_dest), .in_data(in_data),
    .in_ack(in_ack), .out_rdy(out_rdy), .out_dest(out_dest), .out_data(out_data),
    .out_ack(out_ack)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic int route_of(input logic [DEST_W-1:0] d);
    return (d[STAGE] == LEVEL[STAGE]) ? 0 : 1;
  endfunction

  // behavioural reference, advanced on every rising edge
  int m_full[2];
  int m_ack[2];
  int m_prio[2];
  int m_dest[2];
  int m_data[2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin
        m_full[k] = 0; m_ack[k] = 0; m_prio[k] = 0; m_dest[k] = 0; m_data[k] = 0;
      end
    end else begin
      int want[2];
      int win[2];
      for (int i = 0; i < 2; i++)
        want[i] = (in_rdy[i] && m_ack[i] == 0) ? route_of(in_dest[i]) : -1;
      for (int o = 0; o < 2; o++) begin
        win[o] = -1;
        if (m_full[o] == 0) begin
          if (want[0] == o && want[1] == o) win[o] = m_prio[o];
          else if (want[0] == o)            win[o] = 0;
          else if (want[1] == o)            win[o] = 1;
        end
      end
      m_ack[0] = 0; m_ack[1] = 0;
      for (int o = 0; o < 2; o++) begin
        if (win[o] >= 0) begin
          m_ack[win[o]] = 1;
          m_full[o] = 1;
          m_dest[o] = int'(in_dest[win[o]]);
          m_data[o] = int'(in_data[win[o]]);
          m_prio[o] = 1 - win[o];
        end else if (m_full[o] == 1 && out_ack[o]) begin
          m_full[o] = 0;
        end
      end
    end
  end

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      for (int k = 0; k < 2; k++) begin
        chk("R4", "in_ack vs model", int'(in_ack[k]), m_ack[k]);
        chk("R7", "out_rdy vs model", int'(out_rdy[k]), m_full[k]);
        if (m_full[k] == 1) begin
          chk("R7", "out_dest vs model", int'(out_dest[k]), m_dest[k]);
          chk("R7", "out_data vs model", int'(out_data[k]), m_data[k]);
        end
      end
    end
    if (cyc > WDOG) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic offer(input int i, input logic r, input int d, input int v);
    in_rdy[i]  = r;
    in_dest[i] = DEST_W'(d);
    in_data[i] = DATA_W'(v);
  endtask

  int rx_cnt[2];
  int exp_cnt[2];
  int last_seq[2][2];
  int idx[2];

  function automatic int wdest(input int s, input int k);
    return (k * 3 + s * 5 + k / 4) % 8;
  endfunction

  initial begin
    rst_n = 1'b0; in_rdy = '0; in_dest = '0; in_data = '0; out_ack = '0;
    repeat (3) step();
    chk("R1", "out_rdy in reset", int'(out_rdy), 0);
    chk("R1", "in_ack in reset", int'(in_ack), 0);
    rst_n = 1'b1;
    repeat (4) step();
    chk("R1", "out_rdy after reset", int'(out_rdy), 0);
    chk("R1", "in_ack after reset", int'(in_ack), 0);

    // R2: straight route on input 0
    offer(0, 1'b1, 3'b000, 8'h11);
    step();
    chk("R4", "ack0 after take", int'(in_ack), 2'b01);
    chk("R2", "straight rdy", int'(out_rdy), 2'b01);
    chk("R2", "straight data", int'(out_data[0]), 8'h11);
    in_rdy[0] = 1'b0;
    step();
    chk("R4", "ack0 one cycle", int'(in_ack), 0);
    chk("R7", "held without ack", int'(out_rdy[0]), 1);
    step();
    chk("R7", "still held", int'(out_data[0]), 8'h11);
    out_ack[0] = 1'b1;
    step();
    out_ack[0] = 1'b0;
    chk("R7", "released after ack", int'(out_rdy), 0);

    // R3: oblique route, high destination bits ignored
    offer(1, 1'b1, 3'b111, 8'h22);
    step();
    chk("R3", "oblique rdy", int'(out_rdy), 2'b10);
    chk("R3", "oblique dest", int'(out_dest[1]), 3'b111);
    chk("R3", "oblique data", int'(out_data[1]), 8'h22);
    in_rdy[1] = 1'b0; out_ack[1] = 1'b1;
    step();
    out_ack[1] = 1'b0;
    chk("R7", "oblique released", int'(out_rdy), 0);

    // R5: different outputs served together
    offer(0, 1'b1, 3'b010, 8'h33);
    offer(1, 1'b1, 3'b100, 8'h44);
    step();
    chk("R5", "both acked", int'(in_ack), 2'b11);
    chk("R5", "straight gets in1", int'(out_data[0]), 8'h44);
    chk("R5", "oblique gets in0", int'(out_data[1]), 8'h33);
    in_rdy = '0; out_ack = 2'b11;
    step();
    out_ack = '0;
    chk("R7", "both released", int'(out_rdy), 0);

    // R6/R8: contention on straight (preference back at input 0), then blocked
    offer(0, 1'b1, 3'b000, 8'h55);
    offer(1, 1'b1, 3'b001, 8'h66);
    step();
    chk("R6", "input0 wins straight", int'(in_ack), 2'b01);
    chk("R6", "winner data", int'(out_data[0]), 8'h55);
    in_rdy[0] = 1'b0;
    step();
    chk("R8", "loser blocked while full", int'(in_ack), 0);
    step();
    chk("R8", "loser still blocked", int'(in_ack), 0);
    out_ack[0] = 1'b1;
    step();
    out_ack[0] = 1'b0;
    chk("R8", "no take at release edge", int'(in_ack), 0);
    chk("R7", "slot empty", int'(out_rdy[0]), 0);
    step();
    chk("R8", "waiting input taken", int'(in_ack), 2'b10);
    chk("R8", "waiting data", int'(out_data[0]), 8'h66);
    in_rdy[1] = 1'b0; out_ack[0] = 1'b1;
    step();
    out_ack[0] = 1'b0;

    // R6: contention on oblique, preference there is input 1
    offer(0, 1'b1, 3'b010, 8'h77);
    offer(1, 1'b1, 3'b010, 8'h88);
    step();
    chk("R6", "input1 wins oblique", int'(in_ack), 2'b10);
    chk("R6", "oblique winner data", int'(out_data[1]), 8'h88);
    in_rdy[1] = 1'b0; out_ack[1] = 1'b1;
    step();
    out_ack[1] = 1'b0;
    chk("R6", "loser has no ack", int'(in_ack), 0);
    step();
    chk("R6", "loser served next", int'(in_ack), 2'b01);
    chk("R6", "loser data", int'(out_data[1]), 8'h77);
    in_rdy[0] = 1'b0; out_ack[1] = 1'b1;
    step();
    out_ack[1] = 1'b0;

    // stream phase: mixed destinations, sinks stall now and then
    for (int o = 0; o < 2; o++) begin
      rx_cnt[o] = 0; exp_cnt[o] = 0;
      for (int s = 0; s < 2; s++) last_seq[o][s] = -1;
    end
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < NW; k++) exp_cnt[route_of(DEST_W'(wdest(s, k)))]++;
    idx[0] = 0; idx[1] = 0;
    for (int s = 0; s < 2; s++) offer(s, 1'b1, wdest(s, 0), (s << 7) | 0);
    while (idx[0] < NW || idx[1] < NW || rx_cnt[0] + rx_cnt[1] < 2 * NW) begin
      step();
      for (int s = 0; s < 2; s++) begin
        if (in_ack[s]) idx[s]++;
        if (idx[s] < NW) offer(s, 1'b1, wdest(s, idx[s]), (s << 7) | idx[s]);
        else             in_rdy[s] = 1'b0;
      end
      for (int o = 0; o < 2; o++) begin
        out_ack[o] = out_rdy[o] && ((cyc + o) % 3 != 0);
        if (out_ack[o]) begin
          int src;
          int seq;
          src = int'(out_data[o][7]);
          seq = int'(out_data[o][6:0]);
          rx_cnt[o]++;
          chk(o == 0 ? "R2" : "R3", "stream route", route_of(out_dest[o]), o);
          chk("R6", "per-source order", int'(seq > last_seq[o][src]), 1);
          last_seq[o][src] = seq;
        end
      end
    end
    step();
    out_ack = '0;
    chk("R2", "straight word count", rx_cnt[0], exp_cnt[0]);
    chk("R3", "oblique word count", rx_cnt[1], exp_cnt[1]);
    step();
    chk("R7", "drained", int'(out_rdy), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule